// File: doc/BRIEF.md
# SPI-Configured Signal Routing Crossbar

This block is a small routing fabric that sits between a microcontroller and on-board loads such as RGB LED drivers. Each output lane takes its value from one of four sources: a line of primary group A, a line of alternate group B, constant low or constant high. The choice is set at run time by a 2-bit selector register. One selector is shared by a fixed set of lanes (three by default, one RGB LED), and each lane in the set has its own A and B line. The path from the inputs to the outputs is purely combinational and covers all lanes in parallel. Only the selectors are clocked.

The microcontroller writes and reads the selectors through a mode-0 SPI slave port. It uses 16-bit frames and needs no reprogramming of the device. The SPI pins are brought into the system clock domain through two-flop synchronizers. A write takes effect only once chip select rises at the end of a well-formed frame, so a frame that is broken off cannot disturb the routing.

Top module: `sigroute_fabric`

## Requirements
- R1: After reset every selector holds 0, so every lane follows its group A line and `miso` is low.
- R2: Selector code 0 drives lane i with `grp_a[i]`.
- R3: Selector code 1 drives lane i with `grp_b[i]`.
- R4: Selector code 2 drives every lane of its set to 0.
- R5: Selector code 3 drives every lane of its set to 1.
- R6: Selector k governs only lanes 3k to 3k+2, and lanes governed by another selector are unaffected.
- R7: A lane follows a change on its selected input line with no clock edge in between.
- R8: A frame is 16 bits, mode 0, MSB first. Bit 15 = 1 means read and 0 means write, bits 14:8 are the address and bits 7:0 are the data. Selector k sits at address k. A write stores data bits 1:0 only when chip select rises.
- R9: On a read, the addressed value is shifted out MSB first on `miso` during the data byte, with bits 7:2 reading as zero. `miso` is low whenever chip select is high.
- R10: A frame with a bit count other than 16 changes no selector.
- R11: A write to an address other than 0 or 1 changes nothing, and a read from such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the microcontroller |
| spi_miso | output | 1 | SPI data to the microcontroller |
| grp_a | input | 6 | Primary microcontroller lines, one per lane |
| grp_b | input | 6 | Alternate microcontroller lines, one per lane |
| lane_out | output | 6 | Routed outputs; lanes 2:0 and 5:3 each drive one RGB LED |

## Verification
The routing is tried with alternating and complementary bit patterns on groups A and B, so that a lane that picks the wrong group, the wrong bit or the wrong selector shows a mismatch. All four selector codes are applied to one set while the other set holds a different code, which separates shared-selector decoding from cross-talk between sets. Input changes made between clock edges show that the path is combinational. Frames of 15 and 17 bits and frames to unused addresses are followed by readback and output checks, which show that these frames left the configuration alone.

// File: rtl/sigroute_pkg.sv
package sigroute_pkg;

  localparam int unsigned SEL_W      = 2;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FRAME_BITS = 1 + ADDR_W + DATA_W;

  typedef enum logic [SEL_W-1:0] {
    SRC_GRP_A = 2'd0,
    SRC_GRP_B = 2'd1,
    SRC_LOW   = 2'd2,
    SRC_HIGH  = 2'd3
  } route_src_e;

endpackage

// File: rtl/sigroute_in_sync.sv
module sigroute_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic rst_sync_n,
  output logic sclk_s,
  output logic cs_n_s,
  output logic mosi_s
);

  logic [STAGES-1:0] rst_pipe_q, rst_pipe_d;
  logic [STAGES-1:0] sclk_pipe_q, sclk_pipe_d;
  logic [STAGES-1:0] cs_pipe_q, cs_pipe_d;
  logic [STAGES-1:0] mosi_pipe_q, mosi_pipe_d;

  always_comb begin
    rst_pipe_d  = {rst_pipe_q[STAGES-2:0], 1'b1};
    sclk_pipe_d = {sclk_pipe_q[STAGES-2:0], sclk_in};
    cs_pipe_d   = {cs_pipe_q[STAGES-2:0], cs_n_in};
    mosi_pipe_d = {mosi_pipe_q[STAGES-2:0], mosi_in};
  end

  // Reset asserts at once and releases after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q  <= '0;
      sclk_pipe_q <= '0;
      cs_pipe_q   <= '1;
      mosi_pipe_q <= '0;
    end else begin
      rst_pipe_q  <= rst_pipe_d;
      sclk_pipe_q <= sclk_pipe_d;
      cs_pipe_q   <= cs_pipe_d;
      mosi_pipe_q <= mosi_pipe_d;
    end
  end

  assign rst_sync_n = rst_pipe_q[STAGES-1];
  assign sclk_s     = sclk_pipe_q[STAGES-1];
  assign cs_n_s     = cs_pipe_q[STAGES-1];
  assign mosi_s     = mosi_pipe_q[STAGES-1];

endmodule

// File: rtl/sigroute_spi_frame.sv
module sigroute_spi_frame
  import sigroute_pkg::*;
#(
  parameter int unsigned KEEP_W = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              cs_n_raw,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [KEEP_W-1:0] wr_data,
  output logic              miso
);

  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 2);
  localparam int unsigned HDR_BITS  = 1 + ADDR_W;
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LOAD  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_SHIFT = CNT_W'(HDR_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_BITS - 1);

  logic                  sclk_d_q, cs_d_q;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d;
  logic [DATA_W-1:0]     tx_q, tx_d;
  logic                  is_rd_q, is_rd_d;
  logic                  sclk_rise, sclk_fall, cs_start, cs_end;
  logic                  cnt_en, rx_en, tx_load, tx_shift;

  assign sclk_rise = sclk_s & ~sclk_d_q & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_d_q & ~cs_n_s;
  assign cs_start  = ~cs_n_s & cs_d_q;
  assign cs_end    = cs_n_s & ~cs_d_q;

  // Header byte as it stands once its eighth bit arrives.
  assign rd_addr = {rx_q[ADDR_W-2:0], mosi_s};

  assign cnt_en   = sclk_rise & (cnt_q != '1);
  assign rx_en    = sclk_rise;
  assign tx_load  = sclk_rise & (cnt_q == CNT_LOAD);
  assign tx_shift = sclk_fall & (cnt_q >= CNT_SHIFT) & (cnt_q <= CNT_LAST);

  always_comb begin
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    is_rd_d = is_rd_q;
    if (cs_start) begin
      cnt_d   = '0;
      is_rd_d = 1'b0;
    end else begin
      if (cnt_en)   cnt_d = cnt_q + 1'b1;
      if (rx_en)    rx_d  = {rx_q[FRAME_BITS-2:0], mosi_s};
      if (tx_load) begin
        tx_d    = rd_data;
        is_rd_d = rx_q[ADDR_W-1];
      end else if (tx_shift) begin
        tx_d = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cs_d_q   <= 1'b1;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      is_rd_q  <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cs_d_q   <= cs_n_s;
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      is_rd_q  <= is_rd_d;
    end
  end

  assign wr_en   = cs_end & (cnt_q == CNT_FULL) & ~rx_q[FRAME_BITS-1];
  assign wr_addr = rx_q[FRAME_BITS-2 -: ADDR_W];
  assign wr_data = rx_q[KEEP_W-1:0];
  assign miso    = ~cs_n_raw & is_rd_q & tx_q[DATA_W-1];

endmodule

// File: rtl/sigroute_cfg_bank.sv
module sigroute_cfg_bank
  import sigroute_pkg::*;
#(
  parameter int unsigned NUM_SEL = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [SEL_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NUM_SEL*SEL_W-1:0] sel_flat
);

  logic [SEL_W-1:0] sel_q [NUM_SEL];
  logic [SEL_W-1:0] sel_d [NUM_SEL];
  logic [NUM_SEL-1:0] sel_en;

  always_comb begin
    for (int k = 0; k < NUM_SEL; k++) begin
      sel_en[k] = wr_en & (wr_addr == ADDR_W'(k));
      sel_d[k]  = sel_en[k] ? wr_data : sel_q[k];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (rd_addr == ADDR_W'(k)) rd_data = DATA_W'(sel_q[k]);
    end
  end

  generate
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q[g] <= '0;
        else        sel_q[g] <= sel_d[g];
      end
      assign sel_flat[g*SEL_W +: SEL_W] = sel_q[g];
    end
  endgenerate

endmodule

// File: rtl/sigroute_lane_mux.sv
module sigroute_lane_mux
  import sigroute_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             src_a,
  input  logic             src_b,
  output logic             lane
);

  always_comb begin
    unique case (route_src_e'(sel))
      SRC_GRP_A: lane = src_a;
      SRC_GRP_B: lane = src_b;
      SRC_LOW:   lane = 1'b0;
      SRC_HIGH:  lane = 1'b1;
      default:   lane = 1'b0;
    endcase
  end

endmodule

// File: rtl/sigroute_fabric.sv
module sigroute_fabric
  import sigroute_pkg::*;
#(
  parameter int unsigned NUM_SEL       = 2,
  parameter int unsigned LANES_PER_SEL = 3,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               spi_sclk,
  input  logic                               spi_cs_n,
  input  logic                               spi_mosi,
  output logic                               spi_miso,
  input  logic [NUM_SEL*LANES_PER_SEL-1:0]   grp_a,
  input  logic [NUM_SEL*LANES_PER_SEL-1:0]   grp_b,
  output logic [NUM_SEL*LANES_PER_SEL-1:0]   lane_out
);

  localparam int unsigned NUM_LANES = NUM_SEL * LANES_PER_SEL;

  logic                     rst_sync_n;
  logic                     sclk_s, cs_n_s, mosi_s;
  logic [ADDR_W-1:0]        rd_addr, wr_addr;
  logic [DATA_W-1:0]        rd_data;
  logic                     wr_en;
  logic [SEL_W-1:0]         wr_data;
  logic [NUM_SEL*SEL_W-1:0] sel_flat;

  sigroute_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_in   (spi_sclk),
    .cs_n_in   (spi_cs_n),
    .mosi_in   (spi_mosi),
    .rst_sync_n(rst_sync_n),
    .sclk_s    (sclk_s),
    .cs_n_s    (cs_n_s),
    .mosi_s    (mosi_s)
  );

  sigroute_spi_frame #(.KEEP_W(SEL_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sclk_s  (sclk_s),
    .cs_n_s  (cs_n_s),
    .mosi_s  (mosi_s),
    .cs_n_raw(spi_cs_n),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .miso    (spi_miso)
  );

  sigroute_cfg_bank #(.NUM_SEL(NUM_SEL)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .sel_flat(sel_flat)
  );

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      sigroute_lane_mux u_mux (
        .sel  (sel_flat[(i / LANES_PER_SEL) * SEL_W +: SEL_W]),
        .src_a(grp_a[i]),
        .src_b(grp_b[i]),
        .lane (lane_out[i])
      );
    end
  endgenerate

endmodule

// File: rtl/sigroute_checks.sv
module sigroute_checks
  import sigroute_pkg::*;
#(
  parameter int unsigned NUM_SEL       = 2,
  parameter int unsigned LANES_PER_SEL = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             spi_cs_n,
  input logic                             spi_miso,
  input logic [NUM_SEL*LANES_PER_SEL-1:0] grp_a,
  input logic [NUM_SEL*LANES_PER_SEL-1:0] grp_b,
  input logic [NUM_SEL*LANES_PER_SEL-1:0] lane_out,
  input logic [NUM_SEL*SEL_W-1:0]         sel_flat
);

  generate
    for (genvar k = 0; k < NUM_SEL; k++) begin : g_chk
      localparam int unsigned LO = k * LANES_PER_SEL;

      a_r2_group_a: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flat[k*SEL_W +: SEL_W] == 2'd0) |->
        (lane_out[LO +: LANES_PER_SEL] == grp_a[LO +: LANES_PER_SEL]));

      a_r3_group_b: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flat[k*SEL_W +: SEL_W] == 2'd1) |->
        (lane_out[LO +: LANES_PER_SEL] == grp_b[LO +: LANES_PER_SEL]));

      a_r4_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flat[k*SEL_W +: SEL_W] == 2'd2) |->
        (lane_out[LO +: LANES_PER_SEL] == '0));

      a_r5_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flat[k*SEL_W +: SEL_W] == 2'd3) |->
        (lane_out[LO +: LANES_PER_SEL] == '1));
    end
  endgenerate

  a_r8_update_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_flat) |-> spi_cs_n);

  a_r9_miso_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_miso);

endmodule

bind sigroute_fabric sigroute_checks #(
  .NUM_SEL      (NUM_SEL),
  .LANES_PER_SEL(LANES_PER_SEL)
) u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .spi_cs_n(spi_cs_n),
  .spi_miso(spi_miso),
  .grp_a   (grp_a),
  .grp_b   (grp_b),
  .lane_out(lane_out),
  .sel_flat(sel_flat)
);

// File: tb/sigroute_fabric_test.sv
`timescale 1ns/1ps
module sigroute_fabric_test;

  logic       clk;
  logic       rst_n;
  logic       spi_sclk, spi_cs_n, spi_mosi;
  logic       spi_miso;
  logic [5:0] grp_a, grp_b;
  logic [5:0] lane_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;
  logic [1:0] exp_sel [2];
  logic [7:0] rd_val;

  sigroute_fabric uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi),
    .spi_miso(spi_miso),
    .grp_a   (grp_a),
    .grp_b   (grp_b),
    .lane_out(lane_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected lanes from the selector codes of R2-R5.
  function automatic logic [5:0] exp_lanes();
    logic [5:0] r;
    for (int i = 0; i < 6; i++) begin
      case (exp_sel[i/3])
        2'd0: r[i] = grp_a[i];
        2'd1: r[i] = grp_b[i];
        2'd2: r[i] = 1'b0;
        default: r[i] = 1'b1;
      endcase
    end
    return r;
  endfunction

  // Mode-0 transfer of nbits bits, MSB first from word[15]; bits past 16 are 0.
  task automatic spi_xfer(input logic [15:0] word, input int nbits, output logic [7:0] rd);
    rd = '0;
    spi_cs_n = 1'b0;
    #200;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 16) ? word[15-i] : 1'b0;
      #200;
      if (i >= 8 && i < 16) rd[15-i] = spi_miso;
      spi_sclk = 1'b1;
      #200;
      spi_sclk = 1'b0;
    end
    #200;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    #400;
  endtask

  task automatic spi_write(input logic [6:0] addr, input logic [7:0] data);
    logic [7:0] dummy;
    spi_xfer({1'b0, addr, data}, 16, dummy);
  endtask

  task automatic spi_read(input logic [6:0] addr, output logic [7:0] data);
    spi_xfer({1'b1, addr, 8'h00}, 16, data);
  endtask

  task automatic t_reset();
    check("R1 lanes after reset", lane_out, grp_a);
    check("R1 miso after reset", spi_miso, 1'b0);
    spi_read(7'd0, rd_val);
    check("R1 selector 0 reset value", rd_val, 8'h00);
  endtask

  task automatic t_group_a();
    grp_a = 6'b101010; grp_b = 6'b010101; #1;
    check("R2 lanes from group A", lane_out, 6'b101010);
    #4 grp_a = 6'b010011; #1;
    check("R7 change without clock", lane_out, 6'b010011);
  endtask

  task automatic t_group_b();
    spi_write(7'd0, 8'h01); exp_sel[0] = 2'd1;
    grp_a = 6'b000000; grp_b = 6'b111111; #1;
    check("R3 lanes 2:0 from group B", lane_out[2:0], 3'b111);
    check("R6 lanes 5:3 stay on group A", lane_out[5:3], 3'b000);
    #4 grp_b = 6'b000101; #1;
    check("R3 per-lane line of group B", lane_out, exp_lanes());
  endtask

  task automatic t_constants();
    grp_a = 6'b111111; grp_b = 6'b111111;
    spi_write(7'd1, 8'h02); exp_sel[1] = 2'd2; #1;
    check("R4 lanes 5:3 forced low", lane_out[5:3], 3'b000);
    check("R6 lanes 2:0 untouched", lane_out[2:0], 3'b111);
    grp_a = 6'b000000; grp_b = 6'b000000;
    spi_write(7'd1, 8'h03); exp_sel[1] = 2'd3; #1;
    check("R5 lanes 5:3 forced high", lane_out[5:3], 3'b111);
    spi_write(7'd0, 8'h02); exp_sel[0] = 2'd2; #1;
    check("R4 set 0 low, set 1 high", lane_out, 6'b111000);
  endtask

  task automatic t_readback();
    spi_write(7'd0, 8'hFF); exp_sel[0] = 2'd3;
    spi_read(7'd0, rd_val);
    check("R8 only bits 1:0 stored", rd_val, 8'h03);
    spi_write(7'd1, 8'h01); exp_sel[1] = 2'd1;
    spi_read(7'd1, rd_val);
    check("R9 readback of selector 1", rd_val, 8'h01);
    check("R9 miso low after frame", spi_miso, 1'b0);
    grp_a = 6'b100110; grp_b = 6'b011001; #1;
    check("R8 lanes after writes", lane_out, exp_lanes());
  endtask

  task automatic t_undefined();
    spi_write(7'd5, 8'h02);
    spi_write(7'd2, 8'h00);
    #1 check("R11 lanes after stray writes", lane_out, exp_lanes());
    spi_read(7'd0, rd_val);
    check("R11 selector 0 untouched", rd_val, 8'(exp_sel[0]));
    spi_read(7'd1, rd_val);
    check("R11 selector 1 untouched", rd_val, 8'(exp_sel[1]));
    spi_read(7'h40, rd_val);
    check("R11 undefined address reads zero", rd_val, 8'h00);
  endtask

  task automatic t_bad_frames();
    logic [7:0] dummy;
    spi_xfer({1'b0, 7'd0, 8'h00}, 15, dummy);
    spi_xfer({1'b0, 7'd1, 8'h02}, 17, dummy);
    spi_xfer({1'b0, 7'd0, 8'h01}, 8, dummy);
    #1 check("R10 lanes after bad frames", lane_out, exp_lanes());
    spi_read(7'd0, rd_val);
    check("R10 selector 0 kept", rd_val, 8'(exp_sel[0]));
    spi_read(7'd1, rd_val);
    check("R10 selector 1 kept", rd_val, 8'(exp_sel[1]));
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    exp_sel[0] = 2'd0;
    exp_sel[1] = 2'd0;
    rst_n    = 1'b0;
    spi_sclk = 1'b0;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    grp_a    = 6'b110100;
    grp_b    = 6'b001011;
    #103;
    rst_n = 1'b1;
    #100;
    t_reset();
    t_group_a();
    t_group_b();
    t_constants();
    t_readback();
    t_undefined();
    t_bad_frames();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule